// File: doc/BRIEF.md
# Multi-Mode Prescaled Event Timer

This block is an up-counting event timer for a peripheral subsystem. An input tick, either the timer clock enable or a rising edge on an external event pin, feeds an 8-bit prescaler. The prescaler advances a 24-bit counter once every (prescale + 1) ticks. When the counter reaches the software-programmed compare value, the block raises a sticky event flag. What happens next depends on the selected mode: the timer stops (one-shot), restarts from zero (periodic), restarts and flips an output pin (toggle), or runs on through the full counter range and wraps (continuous). The interval from a counter clear to the first match is therefore (prescale + 1) × compare input ticks.

Software drives the block through a small register strobe interface with four word addresses. A write takes effect at the clock edge on which `reg_wr` is high. Read data is combinational from `reg_addr`. The interrupt request is the event flag masked by an enable bit. Software clears the flag by writing 1 to it.

Top module: `evt_timer`

## Requirements
- R1: After reset, all four registers read 0, `irq` is 0 and `tgl_out` is 0.
- R2: Address 0 (control) holds the mode in bits [1:0], the run bit in bit 2, the interrupt enable in bit 3, the external-source select in bit 4, a counter-clear command in bit 5 and the prescale value P in bits [15:8]. Address 1 holds the compare value C in bits [23:0]. Address 2 (status) holds the event flag in bit 0 and the toggle level in bit 1. Address 3 reads the counter. While the run bit is set, the counter advances by one on every (P+1)-th input tick.
- R3: Mode 0 (one-shot): when the counter reaches C, the flag is set, the run bit clears by itself and the counter holds at C.
- R4: Mode 1 (periodic): when the counter reaches C, the flag is set and the counter returns to 0 on that same step.
- R5: Mode 2 (toggle): the counter behaves as in periodic mode, and `tgl_out` inverts on every match.
- R6: Mode 3 (continuous): reaching C sets the flag but does not restart the counter. The counter keeps counting through its all-ones value and wraps to 0.
- R7: Writing status with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged. A match in the same cycle as a clear wins, and the flag stays set.
- R8: A control write with bit 5 = 1 clears the counter, the prescaler phase and `tgl_out`. Bit 5 always reads back as 0.
- R9: `irq` is high exactly when the flag and the interrupt-enable bit are both 1.
- R10: Clearing the run bit freezes the counter at its current value. Setting it again resumes counting from that value.
- R11: With the external source selected, `tick_en` is ignored. Each rising edge of `ext_evt` is one input tick after a two-flop synchroniser, so the counter changes on the third rising clock edge after `ext_evt` rises.
- R12: With the internal source selected, the counter does not move in cycles where `tick_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Internal input tick (clock enable) |
| ext_evt | input | 1 | External event pin, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| tgl_out | output | 1 | Toggle-mode output pin |

## Verification
The hardest situations to reach from the ports are the full-range wrap in continuous mode and a flag clear that lands on the exact cycle of a match. A 24-bit wrap would take far more ticks than a run allows, so a second instance with a 10-bit counter receives the same stimulus and has its wrap checked after 1026 ticks. For the collision, the bench holds `tick_en` high with a compare value of 2. It reads the counter at the falling edge, and when the count is 1 it issues the clear write for the very next edge, which is the edge that produces the match.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic [1:0] {
    MODE_ONCE   = 2'd0,
    MODE_PERIOD = 2'd1,
    MODE_TOGGLE = 2'd2,
    MODE_FREE   = 2'd3
  } tmr_mode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;

  localparam int CTRL_MODE_LSB = 0;
  localparam int CTRL_RUN      = 2;
  localparam int CTRL_IE       = 3;
  localparam int CTRL_EXT      = 4;
  localparam int CTRL_CRST     = 5;
  localparam int CTRL_PSC_LSB  = 8;

  localparam int STAT_FLAG = 0;
  localparam int STAT_TGL  = 1;

endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R11
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [PSC_W-1:0] psc_val,
  output logic             step
);

  logic [PSC_W-1:0] pcnt_q, pcnt_d;

  assign step = adv & ~clr & (pcnt_q == psc_val);

  always_comb begin
    pcnt_d = pcnt_q;
    if (clr)       pcnt_d = '0;
    else if (step) pcnt_d = '0;
    else if (adv)  pcnt_d = pcnt_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R2
  psc_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (pcnt_q == '0));

  // R8
  psc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pcnt_q == '0));

endmodule

// File: rtl/evt_counter_core.sv
module evt_counter_core import evt_timer_pkg::*; #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  tmr_mode_e        mode,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             restart;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign hit     = step & (cnt_inc == cmp);
  assign restart = hit & ((mode == MODE_PERIOD) | (mode == MODE_TOGGLE));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (restart) cnt_d = '0;
    else if (step)    cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R4
  period_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (mode == MODE_PERIOD) && !clr) |=> (cnt_q == '0));

  // R6
  free_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (mode == MODE_FREE) && !clr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/evt_timer.sv
module evt_timer import evt_timer_pkg::*; #(
  parameter int CNT_W       = 24,
  parameter int PSC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        ext_evt,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        tgl_out
);

  localparam int DATA_W = 32;

  tmr_mode_e        mode_q, mode_d;
  logic             run_q, run_d;
  logic             ie_q, ie_d;
  logic             ext_q, ext_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             flag_q, flag_d;
  logic             tgl_q, tgl_d;

  logic             ctrl_wr, cmp_wr, stat_wr, cnt_clr;
  logic             ext_rise, tick_src, adv, step, hit, once_stop;
  logic [CNT_W-1:0] cnt;
  logic             unused_wbits;

  assign ctrl_wr   = reg_wr & (reg_addr == ADDR_CTRL);
  assign cmp_wr    = reg_wr & (reg_addr == ADDR_CMP);
  assign stat_wr   = reg_wr & (reg_addr == ADDR_STAT);
  assign cnt_clr   = ctrl_wr & reg_wdata[CTRL_CRST];
  assign unused_wbits = ^reg_wdata;

  evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ext_evt),
    .rise (ext_rise)
  );

  assign tick_src = ext_q ? ext_rise : tick_en;
  assign adv      = run_q & tick_src;

  evt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cnt_clr),
    .adv    (adv),
    .psc_val(psc_q),
    .step   (step)
  );

  evt_counter_core #(.CNT_W(CNT_W)) u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr),
    .step (step),
    .mode (mode_q),
    .cmp  (cmp_q),
    .cnt  (cnt),
    .hit  (hit)
  );

  assign once_stop = hit & (mode_q == MODE_ONCE);

  always_comb begin
    mode_d = mode_q;
    run_d  = run_q;
    ie_d   = ie_q;
    ext_d  = ext_q;
    psc_d  = psc_q;
    cmp_d  = cmp_q;
    flag_d = flag_q;
    tgl_d  = tgl_q;
    if (ctrl_wr) begin
      mode_d = tmr_mode_e'(reg_wdata[CTRL_MODE_LSB +: 2]);
      run_d  = reg_wdata[CTRL_RUN];
      ie_d   = reg_wdata[CTRL_IE];
      ext_d  = reg_wdata[CTRL_EXT];
      psc_d  = reg_wdata[CTRL_PSC_LSB +: PSC_W];
    end else if (once_stop) begin
      run_d = 1'b0;
    end
    if (cmp_wr) cmp_d = reg_wdata[CNT_W-1:0];
    if (hit) flag_d = 1'b1;
    else if (stat_wr && reg_wdata[STAT_FLAG]) flag_d = 1'b0;
    if (cnt_clr) tgl_d = 1'b0;
    else if (hit && (mode_q == MODE_TOGGLE)) tgl_d = ~tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ONCE;
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      ext_q  <= 1'b0;
      psc_q  <= '0;
      cmp_q  <= '0;
      flag_q <= 1'b0;
      tgl_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      ie_q   <= ie_d;
      ext_q  <= ext_d;
      psc_q  <= psc_d;
      cmp_q  <= cmp_d;
      flag_q <= flag_d;
      tgl_q  <= tgl_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[CTRL_MODE_LSB +: 2]     = mode_q;
        reg_rdata[CTRL_RUN]               = run_q;
        reg_rdata[CTRL_IE]                = ie_q;
        reg_rdata[CTRL_EXT]               = ext_q;
        reg_rdata[CTRL_PSC_LSB +: PSC_W]  = psc_q;
      end
      ADDR_CMP:  reg_rdata[CNT_W-1:0] = cmp_q;
      ADDR_STAT: begin
        reg_rdata[STAT_FLAG] = flag_q;
        reg_rdata[STAT_TGL]  = tgl_q;
      end
      default:   reg_rdata[CNT_W-1:0] = cnt;
    endcase
  end

  assign irq     = flag_q & ie_q;
  assign tgl_out = tgl_q;

  // R3
  once_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (mode_q == MODE_ONCE) && !ctrl_wr) |=> !run_q);

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && stat_wr && reg_wdata[STAT_FLAG] && !hit) |=> !flag_q);

  // R5
  tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (mode_q == MODE_TOGGLE)) |=> (tgl_q != $past(tgl_q)));

  // R8
  tgl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> !tgl_q);

  initial begin
    width_chk: assert (CNT_W <= DATA_W && CTRL_PSC_LSB + PSC_W <= DATA_W);
  end

endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
  import evt_timer_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        ext_evt = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, rdata_w;
  logic        irq, tgl_out, irq_w, tgl_w;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  evt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_evt(ext_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .tgl_out(tgl_out)
  );

  evt_timer #(.CNT_W(10)) u_dut_w (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_evt(ext_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_w), .irq(irq_w), .tgl_out(tgl_w)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  psc;
    logic [23:0] cmp;
    logic [15:0] nt;
    logic [23:0] ecnt;
    logic        eflag;
    logic        etgl;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'd0, 24'd5, 16'd3,  24'd3, 1'b0, 1'b0},
    '{2'd1, 8'd0, 24'd5, 16'd5,  24'd0, 1'b1, 1'b0},
    '{2'd1, 8'd2, 24'd4, 16'd13, 24'd0, 1'b1, 1'b0},
    '{2'd1, 8'd2, 24'd4, 16'd11, 24'd3, 1'b0, 1'b0},
    '{2'd0, 8'd1, 24'd3, 16'd20, 24'd3, 1'b1, 1'b0},
    '{2'd2, 8'd0, 24'd2, 16'd6,  24'd0, 1'b1, 1'b1},
    '{2'd2, 8'd0, 24'd2, 16'd4,  24'd0, 1'b1, 1'b0},
    '{2'd3, 8'd0, 24'd3, 16'd7,  24'd7, 1'b1, 1'b0},
    '{2'd3, 8'd3, 24'd2, 16'd7,  24'd1, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_main(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd_wide(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = rdata_w;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_word(input logic [1:0] m, input logic run,
      input logic ie, input logic ext, input logic crst, input logic [7:0] psc);
    return {16'h0, psc, 2'b00, crst, ext, ie, run, m};
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R2,R3";
      2'd1: return "R2,R4";
      2'd2: return "R2,R5";
      default: return "R2,R6";
    endcase
  endfunction

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd_main(2'(a), v);
      check("R1 reg", v, 32'h0);
    end
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 tgl", {31'h0, tgl_out}, 32'h0);

    // table of mode / prescale vectors
    for (int i = 0; i < NV; i++) begin
      wr_reg(ADDR_CMP, {8'h0, VECS[i].cmp});
      wr_reg(ADDR_CTRL, ctrl_word(VECS[i].mode, 1'b1, 1'b1, 1'b0, 1'b1, VECS[i].psc));
      wr_reg(ADDR_STAT, 32'h1);
      ticks(int'(VECS[i].nt));
      rd_main(ADDR_CNT, v);
      check({mode_tag(VECS[i].mode), " count"}, v, {8'h0, VECS[i].ecnt});
      rd_main(ADDR_STAT, v);
      check({mode_tag(VECS[i].mode), " flag"}, {31'h0, v[0]}, {31'h0, VECS[i].eflag});
      check("R5 tgl_out", {31'h0, tgl_out}, {31'h0, VECS[i].etgl});
      check("R9 irq", {31'h0, irq}, {31'h0, VECS[i].eflag});
      rd_main(ADDR_CTRL, v);
      check("R3 run bit", {31'h0, v[2]},
            {31'h0, !((VECS[i].mode == 2'd0) && VECS[i].eflag)});
    end

    // R7 clear colliding with a match: set wins
    wr_reg(ADDR_CMP, 32'd2);
    wr_reg(ADDR_CTRL, ctrl_word(2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0));
    wr_reg(ADDR_STAT, 32'h1);
    @(negedge clk);
    tick_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_main(ADDR_CNT, v);
    check("R7 pre-collision count", v, 32'd1);
    reg_addr = ADDR_STAT; reg_wdata = 32'h1; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; tick_en = 1'b0;
    rd_main(ADDR_STAT, v);
    check("R7 set wins over clear", {31'h0, v[0]}, 32'h1);
    wr_reg(ADDR_STAT, 32'h0);
    rd_main(ADDR_STAT, v);
    check("R7 write 0 keeps flag", {31'h0, v[0]}, 32'h1);
    wr_reg(ADDR_STAT, 32'h1);
    rd_main(ADDR_STAT, v);
    check("R7 write 1 clears flag", {31'h0, v[0]}, 32'h0);

    // R9 interrupt masking
    ticks(2);
    check("R9 irq enabled", {31'h0, irq}, 32'h1);
    wr_reg(ADDR_CTRL, ctrl_word(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0));
    check("R9 irq masked", {31'h0, irq}, 32'h0);
    rd_main(ADDR_STAT, v);
    check("R9 flag kept while masked", {31'h0, v[0]}, 32'h1);
    wr_reg(ADDR_CTRL, ctrl_word(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0));
    check("R9 irq unmasked", {31'h0, irq}, 32'h1);

    // R10 freeze and R12 tick enable
    wr_reg(ADDR_CMP, 32'd100);
    wr_reg(ADDR_CTRL, ctrl_word(2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0));
    ticks(7);
    rd_main(ADDR_CNT, v);
    check("R10 count before freeze", v, 32'd7);
    repeat (10) @(negedge clk);
    rd_main(ADDR_CNT, v);
    check("R12 no tick no advance", v, 32'd7);
    wr_reg(ADDR_CTRL, ctrl_word(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0));
    ticks(5);
    rd_main(ADDR_CNT, v);
    check("R10 frozen", v, 32'd7);
    wr_reg(ADDR_CTRL, ctrl_word(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0));
    ticks(2);
    rd_main(ADDR_CNT, v);
    check("R10 resumed", v, 32'd9);

    // R8 counter clear also clears prescaler phase
    wr_reg(ADDR_CTRL, ctrl_word(2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd3));
    ticks(5);
    rd_main(ADDR_CNT, v);
    check("R8 count before clear", v, 32'd1);
    wr_reg(ADDR_CTRL, ctrl_word(2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd3));
    rd_main(ADDR_CNT, v);
    check("R8 count cleared", v, 32'd0);
    rd_main(ADDR_CTRL, v);
    check("R8 clear bit reads 0", {31'h0, v[5]}, 32'h0);
    ticks(3);
    rd_main(ADDR_CNT, v);
    check("R8 prescaler phase cleared", v, 32'd0);
    ticks(1);
    rd_main(ADDR_CNT, v);
    check("R8 first step after clear", v, 32'd1);

    // R8 clear resets toggle pin
    wr_reg(ADDR_CMP, 32'd1);
    wr_reg(ADDR_CTRL, ctrl_word(2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0));
    ticks(1);
    check("R5 toggle after one match", {31'h0, tgl_out}, 32'h1);
    wr_reg(ADDR_CTRL, ctrl_word(2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0));
    check("R8 toggle cleared", {31'h0, tgl_out}, 32'h0);

    // R11 external source
    wr_reg(ADDR_CMP, 32'd100);
    wr_reg(ADDR_CTRL, ctrl_word(2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 8'd0));
    ticks(10);
    rd_main(ADDR_CNT, v);
    check("R11 tick_en ignored", v, 32'd0);
    @(negedge clk);
    tick_en = 1'b1;
    ext_evt = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rd_main(ADDR_CNT, v);
    check("R11 latency two edges", v, 32'd0);
    @(posedge clk);
    @(negedge clk);
    rd_main(ADDR_CNT, v);
    check("R11 count on third edge", v, 32'd1);
    for (int k = 0; k < 3; k++) begin
      repeat (3) @(negedge clk);
      ext_evt = 1'b0;
      repeat (3) @(negedge clk);
      ext_evt = 1'b1;
    end
    repeat (6) @(negedge clk);
    tick_en = 1'b0;
    rd_main(ADDR_CNT, v);
    check("R11 four edges", v, 32'd4);
    ext_evt = 1'b0;

    // R6 wrap on the 10-bit instance
    wr_reg(ADDR_CMP, 32'd3);
    wr_reg(ADDR_CTRL, ctrl_word(2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0));
    wr_reg(ADDR_STAT, 32'h1);
    ticks(1026);
    rd_wide(ADDR_CNT, v);
    check("R6 wrapped count", v, 32'd2);
    rd_wide(ADDR_STAT, v);
    check("R6 flag after pass", {31'h0, v[0]}, 32'h1);
    wr_reg(ADDR_STAT, 32'h1);
    ticks(1);
    rd_wide(ADDR_CNT, v);
    check("R6 count after wrap", v, 32'd3);
    rd_wide(ADDR_STAT, v);
    check("R6 match again after wrap", {31'h0, v[0]}, 32'h1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule